// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Read Slave

This block is the serial side of a small three-wire memory that holds 16-bit words and answers only the read command. A host raises chip select and clocks bits in on the serial clock. The bits are a start marker, a two-bit command code and a word address, most significant bit first. After the last address bit the block starts driving its data output. It first sends one zero bit and then the stored word from bit 15 down to bit 0. While chip select stays high and the clock keeps running, the following words come out back to back with no gap. The address climbs by one per word and wraps from the top of memory to word zero.

The serial pins come from off-chip. They are brought into the block's own clock domain through a synchronizer, and the serial clock's rising edge is detected there. Each output change therefore appears a fixed number of system clocks after the serial clock edge that caused it, well before the host samples on its next edge. The output-enable stands for the tri-state control of the data pin. A write port on the system clock lets the surrounding logic, or a bench, preload the word array. A parameter selects 64 words (6 address bits) or 128 words (7 address bits).

Top module: `eep_rd_slave`

## Requirements
- R1: While chip select is low, `do_oe_o` and `do_o` are 0, and serial clock edges and data-in values have no effect. Whenever `do_oe_o` is 0, `do_o` is also 0.
- R2: With chip select high and no command in progress, a serial clock rising edge that samples data-in low is a dummy clock: it is ignored, and the block still waits for a start marker.
- R3: A rising edge that samples data-in high is the start marker. The next two sampled bits are the command code, and only the code 1 followed by 0 is a read. Any other code leaves the output disabled until chip select goes low.
- R4: After a read code, the address field is clocked in most significant bit first. The field is `ADDR_W` bits wide, rounded up to an even count. When `ADDR_W` is odd, one leading don't-care bit comes first (8 field bits for 128 words, 6 for 64 words).
- R5: The rising edge that latches the last address bit sets `do_oe_o` to 1 and `do_o` to 0, which is the single zero bit.
- R6: Each of the next 16 rising edges puts one bit of the addressed word on `do_o`, from bit 15 down to bit 0.
- R7: With chip select still high, the rising edge after bit 0 presents bit 15 of the word at the next address, with no further zero bit. This repeats for as long as clocking continues.
- R8: The address after the highest one (all ones) is address 0.
- R9: Lowering chip select in the middle of a command or a read discards it. A later command is decoded from scratch.
- R10: `do_o` and `do_oe_o` change on the third rising edge of `clk` after the serial clock or chip select input changes (two synchronizer stages and one output register). They hold steady in every other cycle while chip select is high.
- R11: When `ld_we_i` is 1 on a rising edge of `clk`, `ld_data_i` is stored at word `ld_addr_i`. A later read returns that value.
- R12: While the reset is asserted and after it is released, `do_oe_o` and `do_o` are 0 and the block waits for a start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_i | input | 1 | Chip select from the host, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| ld_we_i | input | 1 | Preload write enable |
| ld_addr_i | input | ADDR_W | Preload word address |
| ld_data_i | input | WORD_W | Preload word value |
| do_o | output | 1 | Serial data to the host |
| do_oe_o | output | 1 | Drive enable of the serial data pin (0 = high impedance) |

## Verification
The hardest situation to reach from the ports is a partly decoded command abandoned by chip select. A design that fails to clear it would read the next command's bits as the rest of the old address. The stimulus sends a start marker, the read code and three address bits, then drops chip select. It keeps toggling the clock and data pins while deselected, then issues a fresh command that begins with a dummy clock. Only a full reset of the decoder makes that command return the right word. The wrap from the highest address to zero is reached by starting a read two words below the top and clocking three whole words, so the stream crosses the boundary without a restart.

// File: rtl/eep_rd_pkg.sv
package eep_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,   // waiting for start marker, dummy clocks absorbed
    ST_OPC  = 3'd1,   // collecting the two command bits
    ST_ADR  = 3'd2,   // collecting the address field
    ST_DAT  = 3'd3,   // streaming words
    ST_SKIP = 3'd4    // unsupported command, silent until deselect
  } eep_state_e;

  localparam logic [1:0] OPC_READ = 2'b10;

endpackage

// File: rtl/eep_rd_sync.sv
module eep_rd_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cs_pin,
  input  logic sk_pin,
  input  logic di_pin,
  output logic rst_n,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise
);

  logic [1:0]                  rst_q;
  logic [2:0]                  pin_v;
  logic [SYNC_STAGES-1:0][2:0] stg_q;
  logic                        sk_s;
  logic                        sk_d;

  // reset: asserted asynchronously, released after two clean edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  assign pin_v = {cs_pin, sk_pin, di_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[SYNC_STAGES-2:0], pin_v};
  end

  assign cs_s = stg_q[SYNC_STAGES-1][2];
  assign sk_s = stg_q[SYNC_STAGES-1][1];
  assign di_s = stg_q[SYNC_STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_d <= 1'b0;
    else        sk_d <= sk_s;
  end

  assign sk_rise = sk_s & ~sk_d;

endmodule

// File: rtl/eep_rd_store.sv
module eep_rd_store #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_we) mem_q[ld_addr] <= ld_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/eep_rd_ctrl.sv
module eep_rd_ctrl
  import eep_rd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              di_s,
  input  logic              sk_rise,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sd_out,
  output logic              sd_oe,
  output eep_state_e        state
);

  localparam int FIELD_W = ADDR_W + (ADDR_W % 2);
  localparam int CNT_MAX = (WORD_W > FIELD_W) ? WORD_W : FIELD_W;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] FIELD_LAST = CNT_W'(FIELD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST  = CNT_W'(WORD_W - 1);

  eep_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              opc_q, opc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              out_q, out_d;
  logic              oe_q, oe_d;
  logic [ADDR_W-1:0] addr_shift;

  assign addr_shift = {addr_q[ADDR_W-2:0], di_s};
  assign rd_addr    = (state_q == ST_ADR) ? addr_shift : addr_q + ADDR_W'(1);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opc_d   = opc_q;
    addr_d  = addr_q;
    sh_d    = sh_q;
    out_d   = out_q;
    oe_d    = oe_q;
    if (!cs_s) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      out_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (sk_rise) begin
      unique case (state_q)
        ST_IDLE: begin
          if (di_s) begin
            state_d = ST_OPC;
            cnt_d   = '0;
          end
        end
        ST_OPC: begin
          if (cnt_q == '0) begin
            opc_d = di_s;
            cnt_d = CNT_W'(1);
          end else if ({opc_q, di_s} == OPC_READ) begin
            state_d = ST_ADR;
            cnt_d   = '0;
          end else begin
            state_d = ST_SKIP;
          end
        end
        ST_ADR: begin
          addr_d = addr_shift;
          if (cnt_q == FIELD_LAST) begin
            state_d = ST_DAT;
            cnt_d   = '0;
            sh_d    = rd_data;
            oe_d    = 1'b1;
            out_d   = 1'b0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_DAT: begin
          out_d = sh_q[WORD_W-1];
          if (cnt_q == WORD_LAST) begin
            cnt_d  = '0;
            sh_d   = rd_data;
            addr_d = addr_q + ADDR_W'(1);
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
            sh_d  = {sh_q[WORD_W-2:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= 1'b0;
      addr_q  <= '0;
      sh_q    <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      addr_q  <= addr_d;
      sh_q    <= sh_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
    end
  end

  assign sd_out = out_q;
  assign sd_oe  = oe_q;
  assign state  = state_q;

endmodule

// File: rtl/eep_rd_slave.sv
module eep_rd_slave
  import eep_rd_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              ld_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [WORD_W-1:0] ld_data_i,
  output logic              do_o,
  output logic              do_oe_o
);

  logic              rst_n;
  logic              cs_s;
  logic              di_s;
  logic              sk_rise;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  eep_state_e        ctl_state;

  eep_rd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .cs_pin  (cs_i),
    .sk_pin  (sk_i),
    .di_pin  (di_i),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .di_s    (di_s),
    .sk_rise (sk_rise)
  );

  eep_rd_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .ld_we   (ld_we_i),
    .ld_addr (ld_addr_i),
    .ld_data (ld_data_i),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  eep_rd_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .di_s    (di_s),
    .sk_rise (sk_rise),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .sd_out  (do_o),
    .sd_oe   (do_oe_o),
    .state   (ctl_state)
  );

endmodule

// File: rtl/eep_rd_slave_chk.sv
module eep_rd_slave_chk
  import eep_rd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       di_s,
  input logic       sk_rise,
  input eep_state_e state,
  input logic       sd_out,
  input logic       sd_oe
);

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (!sd_oe && !sd_out)); // R1

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out); // R1

  AST_DUMMY_CLOCK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && sk_rise && !di_s && state == ST_IDLE) |=> state == ST_IDLE); // R2

  AST_BAD_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SKIP |-> !sd_oe); // R3

  AST_OE_AFTER_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> ($past(sk_rise) && $past(state) == ST_ADR)); // R4

  AST_LEADING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> !sd_out); // R5

  AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !sk_rise) |=> ($stable(sd_out) && $stable(sd_oe))); // R10

endmodule

bind eep_rd_slave eep_rd_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_s    (cs_s),
  .di_s    (di_s),
  .sk_rise (sk_rise),
  .state   (ctl_state),
  .sd_out  (do_o),
  .sd_oe   (do_oe_o)
);

// File: tb/eep_rd_slave_test.sv
`timescale 1ns/1ps
module eep_rd_slave_test;

  localparam int ADDR_W  = 7;
  localparam int WORD_W  = 16;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int FIELD_W = ADDR_W + (ADDR_W % 2);

  logic              clk = 1'b0;
  logic              arst_n;
  logic              cs_i, sk_i, di_i;
  logic              ld_we_i;
  logic [ADDR_W-1:0] ld_addr_i;
  logic [WORD_W-1:0] ld_data_i;
  logic              do_o, do_oe_o;

  always #2 clk = ~clk;

  eep_rd_slave #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) uut (
    .clk(clk), .arst_n(arst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
    .ld_we_i(ld_we_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .do_o(do_o), .do_oe_o(do_oe_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R12";
  bit    cmp_en = 1'b0;
  logic  exp_do = 1'b0;
  logic  exp_oe = 1'b0;

  // behavioural reference
  logic [WORD_W-1:0] ref_mem [DEPTH];
  bit   m_cs = 1'b0;
  int   m_mode = 0;   // 0 wait start, 1 code, 2 address, 3 stream, 4 ignore
  int   m_cnt = 0;
  int   m_first = 0;
  int   m_addr = 0;
  bit   m_bits [$];

  function automatic logic [WORD_W-1:0] pattern(int a);
    return WORD_W'((a * 37 + 16'h5A3C) ^ (a << 9));
  endfunction

  task automatic push_word(int a);
    for (int i = WORD_W - 1; i >= 0; i--) m_bits.push_back(ref_mem[a][i]);
  endtask

  task automatic model_rise(bit d);
    if (!m_cs) return;
    case (m_mode)
      0: if (d) begin m_mode = 1; m_cnt = 0; end
      1: begin
        if (m_cnt == 0) begin m_first = d; m_cnt = 1; end
        else if (m_first == 1 && d == 0) begin m_mode = 2; m_cnt = 0; m_addr = 0; end
        else m_mode = 4;
      end
      2: begin
        m_addr = ((m_addr << 1) | d) % DEPTH;
        m_cnt++;
        if (m_cnt == FIELD_W) begin
          m_mode = 3; exp_oe = 1'b1; exp_do = 1'b0;
          m_bits.delete();
          push_word(m_addr);
        end
      end
      3: begin
        if (m_bits.size() == 0) begin
          m_addr = (m_addr + 1) % DEPTH;
          push_word(m_addr);
        end
        exp_do = m_bits.pop_front();
      end
      default: ;
    endcase
  endtask

  // per-clock comparison
  always @(posedge clk) begin
    #1;
    if (cmp_en) begin
      n_cmp++;
      if (do_o !== exp_do || do_oe_o !== exp_oe) begin
        n_bad++;
        $display("FAIL %s/R10 t=%0t actual do=%b oe=%b expected do=%b oe=%b",
                 cur_req, $time, do_o, do_oe_o, exp_do, exp_oe);
      end
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick_bit(bit d);
    @(negedge clk) di_i = d;
    repeat (3) @(negedge clk);
    sk_i = 1'b1;
    repeat (3) @(posedge clk);
    model_rise(d);
    repeat (3) @(negedge clk);
    sk_i = 1'b0;
  endtask

  task automatic set_cs(bit v);
    @(negedge clk) cs_i = v;
    repeat (3) @(posedge clk);
    m_cs = v;
    if (!v) begin
      m_mode = 0; exp_oe = 1'b0; exp_do = 1'b0; m_bits.delete();
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic send_read(int a);
    tick_bit(1'b1);
    tick_bit(1'b1);
    tick_bit(1'b0);
    for (int i = FIELD_W - 1; i >= 0; i--)
      tick_bit((i < ADDR_W) ? a[i] : 1'b1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    arst_n = 1'b0; cs_i = 1'b0; sk_i = 1'b0; di_i = 1'b0;
    ld_we_i = 1'b0; ld_addr_i = '0; ld_data_i = '0;
    repeat (5) @(posedge clk);
    cmp_en = 1'b1;
    @(negedge clk) arst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R12", do_oe_o, 1'b0, "oe after reset");
    check("R12", do_o, 1'b0, "do after reset");

    // R11 preload
    cur_req = "R11";
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_we_i = 1'b1; ld_addr_i = ADDR_W'(i); ld_data_i = pattern(i);
      ref_mem[i] = pattern(i);
    end
    @(negedge clk) ld_we_i = 1'b0;

    // R1 standby: clocking while deselected does nothing
    cur_req = "R1";
    send_read(3);
    repeat (4) tick_bit(1'b1);
    check("R1", do_oe_o, 1'b0, "oe while deselected");

    // R2 dummy clocks, R3/R4/R5/R6/R7 single and following word
    set_cs(1'b1);
    cur_req = "R2";
    repeat (3) tick_bit(1'b0);
    check("R2", do_oe_o, 1'b0, "oe after dummy clocks");
    cur_req = "R4";
    send_read(5);
    check("R5", do_oe_o, 1'b1, "oe after last address bit");
    check("R5", do_o, 1'b0, "leading zero bit");
    cur_req = "R6";
    repeat (WORD_W) tick_bit(1'b0);
    check("R6", do_o, ref_mem[5][0], "bit 0 of word 5");
    cur_req = "R7";
    tick_bit(1'b0);
    check("R7", do_o, ref_mem[6][WORD_W-1], "bit 15 of word 6 with no gap");
    repeat (WORD_W - 1) tick_bit(1'b1);
    cur_req = "R1";
    set_cs(1'b0);
    check("R1", do_oe_o, 1'b0, "oe after deselect");

    // R8 wrap across the top address
    set_cs(1'b1);
    cur_req = "R8";
    send_read(DEPTH - 2);
    repeat (3 * WORD_W) tick_bit(1'b0);
    check("R8", do_o, ref_mem[0][0], "last bit of word 0 after wrap");
    set_cs(1'b0);

    // R9 abandoned command
    set_cs(1'b1);
    cur_req = "R9";
    tick_bit(1'b1); tick_bit(1'b1); tick_bit(1'b0);
    tick_bit(1'b0); tick_bit(1'b1); tick_bit(1'b1);
    set_cs(1'b0);
    tick_bit(1'b1); tick_bit(1'b0); tick_bit(1'b1);
    set_cs(1'b1);
    tick_bit(1'b0);
    send_read(40);
    check("R9", do_oe_o, 1'b1, "fresh command after abort");
    repeat (WORD_W) tick_bit(1'b0);
    check("R9", do_o, ref_mem[40][0], "word 40 bit 0");
    set_cs(1'b0);

    // R3 unsupported codes stay silent
    set_cs(1'b1);
    cur_req = "R3";
    tick_bit(1'b1); tick_bit(1'b1); tick_bit(1'b1);
    repeat (FIELD_W + 4) tick_bit(1'b1);
    check("R3", do_oe_o, 1'b0, "oe after code 11");
    set_cs(1'b0);
    set_cs(1'b1);
    tick_bit(1'b1); tick_bit(1'b0); tick_bit(1'b0);
    repeat (FIELD_W + 4) tick_bit(1'b0);
    check("R3", do_oe_o, 1'b0, "oe after code 00");
    set_cs(1'b0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule